// File: doc/BRIEF.md
# Automatic Crossover Link Bring-Up Sequencer

This block brings up a copper LAN port whose PHY has no crossover detection of its own. Out of reset it selects the straight (MDI) pair assignment, waits a programmable interval, then asks the PHY through an MDIO request/acknowledge handshake whether link is up. Each failed check flips the pair assignment between MDI and MDIX, and the sequencer tries again. Once the retry budget is used up, it stops and raises a failure flag.

When link is found, the block walks a short chain of PHY register reads. From these it resolves line speed, duplex and symmetric pause. It then writes a four-bit port status word and pulses a done strobe. The MDIO serializer sits outside this block: it takes the register address while the request is high, and it returns the read data together with a one-cycle acknowledge.

Top module: `mdix_link_seq`

## Requirements
- R1: While reset is low and right after it is released, `xover_o` is 0 (MDI), `fail_o`, `done_o` and `mdio_req_o` are 0, and `status_o` is 0. No request is issued before the first wait interval has elapsed.
- R2: Every check of the link bit comes after a wait of at least `RETRY_CYCLES` clock cycles, counted from reset release or from the previous link check.
- R3: A link check reads PHY register 1, and bit 2 of the returned data set means link up. Every read drives PHY address 6 on `mdio_phy_o`. `mdio_req_o` stays high with a stable `mdio_reg_o` until `mdio_ack_i` is seen.
- R4: After each link check that returns bit 2 clear, `xover_o` inverts (0 = MDI, 1 = MDIX), so check k (counted from 0) runs with `xover_o` = k mod 2.
- R5: After `MAX_RETRIES` failed link checks, `fail_o` goes high and stays high. After that no request is issued and `done_o` never pulses.
- R6: Once link is found, register 1 is read a second time. If bit 5 of that read is clear, the sequence ends with only the link flag set.
- R7: If bit 5 is set, register 31 is read and its bits 4:2 are decoded: 1 gives 10 Mb/s half duplex, 5 gives 10 Mb/s full duplex, 2 gives 100 Mb/s half duplex, 6 gives 100 Mb/s full duplex. Any other code sets neither the speed flag nor the duplex flag.
- R8: After the register 31 read, if bit 3 of the second register-1 read was set, the sequencer reads register 6. If bit 0 of register 6 is set, it reads register 4. If bit 10 of register 4 is set, it reads register 5. The pause flag is set only when bit 10 of register 5 is also set. Any clear bit ends the chain.
- R9: `status_o` is bit 0 link, bit 1 100 Mb/s, bit 2 full duplex, bit 3 pause. It changes only together with a one-cycle `done_o` pulse. The link bit is 1 whenever done pulses. Afterwards the status holds and no further request is issued.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mdio_req_o | output | 1 | Read request, held until acknowledged |
| mdio_phy_o | output | 5 | PHY address of the read |
| mdio_reg_o | output | 5 | Register address of the read |
| mdio_ack_i | input | 1 | One-cycle acknowledge, data valid |
| mdio_rdata_i | input | 16 | Read data, valid with acknowledge |
| xover_o | output | 1 | Pair assignment select, 0 = MDI, 1 = MDIX |
| status_o | output | 4 | Port status word |
| done_o | output | 1 | One-cycle pulse when the status word is written |
| fail_o | output | 1 | Link not found within the retry budget |

## Verification
The properties assume that the serializer raises `mdio_ack_i` only while `mdio_req_o` is high, for exactly one cycle per request, with `mdio_rdata_i` valid in that same cycle. The bench's PHY model keeps to this. It waits at the falling edge until it sees a request, lets two more cycles pass, presents data and the acknowledge for one cycle, and only then looks for the next request. So a back-to-back read in the chain is always a fresh request, never a double acknowledge. The model also decides link per check index rather than per pair setting, which keeps the expected crossover value a plain parity of the attempt number.

// File: rtl/mdix_pkg.sv
package mdix_pkg;
  typedef enum logic [3:0] {
    ST_ARM, ST_WAIT, ST_RD_LINK, ST_RD_ANC, ST_RD_SPD,
    ST_RD_ANER, ST_RD_ADV, ST_RD_LP, ST_FIN, ST_DONE, ST_FAIL
  } seq_state_e;

  localparam logic [4:0] PHY_LAN   = 5'd6;
  localparam logic [4:0] REG_BSR   = 5'd1;
  localparam logic [4:0] REG_ADV   = 5'd4;
  localparam logic [4:0] REG_LP    = 5'd5;
  localparam logic [4:0] REG_ANER  = 5'd6;
  localparam logic [4:0] REG_SCSR  = 5'd31;

  localparam int BIT_LINK  = 2;
  localparam int BIT_ANE   = 3;
  localparam int BIT_ANC   = 5;
  localparam int BIT_LPAN  = 0;
  localparam int BIT_PAUSE = 10;

  localparam logic [2:0] SPD_10H  = 3'd1;
  localparam logic [2:0] SPD_10F  = 3'd5;
  localparam logic [2:0] SPD_100H = 3'd2;
  localparam logic [2:0] SPD_100F = 3'd6;
endpackage

// File: rtl/mdix_delay_timer.sv
module mdix_delay_timer #(
  parameter int CYCLES = 1000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic expire_o
);
  localparam int CW = $clog2(CYCLES + 1);
  localparam logic [CW-1:0] LOAD = CW'(CYCLES - 1);

  logic [CW-1:0] cnt_q;
  logic          run_q;

  assign expire_o = run_q && (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      run_q <= 1'b0;
    end else if (start_i) begin
      cnt_q <= LOAD;
      run_q <= 1'b1;
    end else if (run_q) begin
      if (cnt_q == '0) run_q <= 1'b0;
      else             cnt_q <= cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/mdix_speed_decode.sv
module mdix_speed_decode
  import mdix_pkg::*;
(
  input  logic [2:0] code_i,
  output logic       fast_o,
  output logic       full_o
);
  always_comb begin
    fast_o = 1'b0;
    full_o = 1'b0;
    case (code_i)
      SPD_10H:  ;
      SPD_10F:  full_o = 1'b1;
      SPD_100H: fast_o = 1'b1;
      SPD_100F: begin fast_o = 1'b1; full_o = 1'b1; end
      default:  ;
    endcase
  end
endmodule

// File: rtl/mdix_link_seq.sv
module mdix_link_seq
  import mdix_pkg::*;
#(
  parameter int RETRY_CYCLES = 200_000_000,
  parameter int MAX_RETRIES  = 100
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  output logic        mdio_req_o,
  output logic [4:0]  mdio_phy_o,
  output logic [4:0]  mdio_reg_o,
  input  logic        mdio_ack_i,
  input  logic [15:0] mdio_rdata_i,
  output logic        xover_o,
  output logic [3:0]  status_o,
  output logic        done_o,
  output logic        fail_o
);
  localparam int RW = $clog2(MAX_RETRIES + 1);
  localparam logic [RW-1:0] LAST_TRY = RW'(MAX_RETRIES - 1);

  seq_state_e    state_q, state_d;
  logic [RW-1:0] retry_q;
  logic          xover_q, ane_q, fast_q, full_q, pause_q, done_q;
  logic [3:0]    status_q;
  logic          expire, dec_fast, dec_full, got;
  logic          unused_rdata;

  assign unused_rdata = ^{mdio_rdata_i[15:11], mdio_rdata_i[9:6], mdio_rdata_i[1]};

  mdix_delay_timer #(.CYCLES(RETRY_CYCLES)) i_timer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (state_q == ST_ARM),
    .expire_o (expire)
  );

  mdix_speed_decode i_decode (
    .code_i (mdio_rdata_i[4:2]),
    .fast_o (dec_fast),
    .full_o (dec_full)
  );

  always_comb begin
    mdio_req_o = 1'b1;
    mdio_reg_o = REG_BSR;
    case (state_q)
      ST_RD_LINK, ST_RD_ANC: mdio_reg_o = REG_BSR;
      ST_RD_SPD:  mdio_reg_o = REG_SCSR;
      ST_RD_ANER: mdio_reg_o = REG_ANER;
      ST_RD_ADV:  mdio_reg_o = REG_ADV;
      ST_RD_LP:   mdio_reg_o = REG_LP;
      default:    mdio_req_o = 1'b0;
    endcase
  end

  assign mdio_phy_o = PHY_LAN;
  assign got        = mdio_req_o && mdio_ack_i;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_ARM:     state_d = ST_WAIT;
      ST_WAIT:    if (expire) state_d = ST_RD_LINK;
      ST_RD_LINK: if (got) begin
        if (mdio_rdata_i[BIT_LINK]) state_d = ST_RD_ANC;
        else if (retry_q == LAST_TRY) state_d = ST_FAIL;
        else state_d = ST_ARM;
      end
      ST_RD_ANC:  if (got) state_d = mdio_rdata_i[BIT_ANC] ? ST_RD_SPD : ST_FIN;
      ST_RD_SPD:  if (got) state_d = ane_q ? ST_RD_ANER : ST_FIN;
      ST_RD_ANER: if (got) state_d = mdio_rdata_i[BIT_LPAN] ? ST_RD_ADV : ST_FIN;
      ST_RD_ADV:  if (got) state_d = mdio_rdata_i[BIT_PAUSE] ? ST_RD_LP : ST_FIN;
      ST_RD_LP:   if (got) state_d = ST_FIN;
      ST_FIN:     state_d = ST_DONE;
      default:    state_d = state_q;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_ARM;
      retry_q  <= '0;
      xover_q  <= 1'b0;
      ane_q    <= 1'b0;
      fast_q   <= 1'b0;
      full_q   <= 1'b0;
      pause_q  <= 1'b0;
      status_q <= '0;
      done_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= 1'b0;
      if (got) begin
        case (state_q)
          ST_RD_LINK: if (!mdio_rdata_i[BIT_LINK]) begin
            xover_q <= ~xover_q;
            retry_q <= retry_q + 1'b1;
          end
          ST_RD_ANC: ane_q <= mdio_rdata_i[BIT_ANE];
          ST_RD_SPD: begin
            fast_q <= dec_fast;
            full_q <= dec_full;
          end
          ST_RD_LP:  pause_q <= mdio_rdata_i[BIT_PAUSE];
          default: ;
        endcase
      end
      if (state_q == ST_FIN) begin
        status_q <= {pause_q, full_q, fast_q, 1'b1};
        done_q   <= 1'b1;
      end
    end
  end

  assign xover_o  = xover_q;
  assign status_o = status_q;
  assign done_o   = done_q;
  assign fail_o   = (state_q == ST_FAIL);
endmodule

// File: rtl/mdix_link_seq_chk.sv
module mdix_link_seq_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       mdio_req_o,
  input logic [4:0] mdio_phy_o,
  input logic [4:0] mdio_reg_o,
  input logic       mdio_ack_i,
  input logic       xover_o,
  input logic [3:0] status_o,
  input logic       done_o,
  input logic       fail_o
);
  AST_REQ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mdio_req_o && !mdio_ack_i |=> mdio_req_o && $stable(mdio_reg_o)); // R3
  AST_PHY_ADDR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mdio_req_o |-> mdio_phy_o == 5'd6); // R3
  AST_XOVER_ON_CHECK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(xover_o) |-> $past(mdio_req_o && mdio_ack_i && mdio_reg_o == 5'd1)); // R4
  AST_FAIL_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fail_o |=> fail_o && !mdio_req_o && !done_o); // R5
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R9
  AST_DONE_LINK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> status_o[0]); // R9
  AST_STATUS_WITH_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(status_o) |-> done_o); // R9
endmodule

bind mdix_link_seq mdix_link_seq_chk i_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .mdio_req_o (mdio_req_o),
  .mdio_phy_o (mdio_phy_o),
  .mdio_reg_o (mdio_reg_o),
  .mdio_ack_i (mdio_ack_i),
  .xover_o    (xover_o),
  .status_o   (status_o),
  .done_o     (done_o),
  .fail_o     (fail_o)
);

// File: tb/test_mdix_link_seq.sv
module test_mdix_link_seq;
  localparam int CLK_PERIOD = 10;
  localparam int RETRY      = 20;
  localparam int MAXR       = 4;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        ack = 1'b0;
  logic [15:0] rdata = '0;
  logic        req, xover, done, fail;
  logic [4:0]  phy, regad;
  logic [3:0]  status;

  int checks = 0, fails = 0, cyc = 0;

  mdix_link_seq #(.RETRY_CYCLES(RETRY), .MAX_RETRIES(MAXR)) i_mdix_link_seq (
    .clk_i(clk), .rst_ni(rst_n), .mdio_req_o(req), .mdio_phy_o(phy),
    .mdio_reg_o(regad), .mdio_ack_i(ack), .mdio_rdata_i(rdata),
    .xover_o(xover), .status_o(status), .done_o(done), .fail_o(fail)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  typedef struct packed {
    logic [3:0] link_at;
    logic       anc, ane;
    logic [2:0] code;
    logic       aner, adv, lp;
    logic [3:0] exp_status;
    logic       exp_fail, exp_xover;
    logic [3:0] exp_reads;
  } vec_t;

  // link_at = index of first link check that sees link; 15 = never
  localparam vec_t VECS [8] = '{
    '{4'd0,  1'b1, 1'b1, 3'd6, 1'b1, 1'b1, 1'b1, 4'b1111, 1'b0, 1'b0, 4'd6},
    '{4'd1,  1'b1, 1'b0, 3'd1, 1'b0, 1'b0, 1'b0, 4'b0001, 1'b0, 1'b1, 4'd4},
    '{4'd2,  1'b1, 1'b1, 3'd5, 1'b0, 1'b1, 1'b1, 4'b0101, 1'b0, 1'b0, 4'd6},
    '{4'd3,  1'b1, 1'b1, 3'd2, 1'b1, 1'b0, 1'b1, 4'b0011, 1'b0, 1'b1, 4'd8},
    '{4'd0,  1'b0, 1'b1, 3'd6, 1'b1, 1'b1, 1'b1, 4'b0001, 1'b0, 1'b0, 4'd2},
    '{4'd1,  1'b1, 1'b1, 3'd6, 1'b1, 1'b1, 1'b0, 4'b0111, 1'b0, 1'b1, 4'd7},
    '{4'd15, 1'b1, 1'b1, 3'd6, 1'b1, 1'b1, 1'b1, 4'b0000, 1'b1, 1'b0, 4'd4},
    '{4'd0,  1'b1, 1'b0, 3'd3, 1'b1, 1'b1, 1'b1, 4'b0001, 1'b0, 1'b0, 4'd3}
  };

  // PHY model state
  vec_t cur;
  int   n_att, reads, addr_err, last_chk, min_gap, xover_err;
  logic linked;

  task automatic chk(input string rq, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", rq, what, act, exp);
    end
  endtask

  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && req) begin
        repeat (2) @(negedge clk);
        reads++;
        if (phy != 5'd6) addr_err++;
        case (regad)
          5'd1: begin
            logic lk;
            if (!linked) begin
              if (cyc - last_chk < min_gap) min_gap = cyc - last_chk;
              last_chk = cyc;
              if (xover != 1'(n_att % 2)) xover_err++;
              lk = (n_att >= int'(cur.link_at));
              if (lk) linked = 1'b1;
              n_att++;
            end else lk = 1'b1;
            rdata = {10'b0, cur.anc, 1'b0, cur.ane, lk, 2'b00};
          end
          5'd31:   rdata = {11'b0, cur.code, 2'b00};
          5'd6:    rdata = {15'b0, cur.aner};
          5'd4:    rdata = {5'b0, cur.adv, 10'b0};
          5'd5:    rdata = {5'b0, cur.lp, 10'b0};
          default: rdata = '0;
        endcase
        ack = 1'b1;
        @(negedge clk);
        ack = 1'b0;
        rdata = '0;
      end
    end
  end

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    n_att = 0; reads = 0; addr_err = 0; min_gap = 1 << 30; xover_err = 0;
    linked = 1'b0;
    rst_n = 1'b1;
    last_chk = cyc;
  endtask

  task automatic run_vec(input vec_t v, input int idx);
    int   t;
    logic seen_done, seen_fail;
    logic [3:0] st_hold;
    cur = v;
    do_reset();
    seen_done = 1'b0; seen_fail = 1'b0; t = 0;
    while (!seen_done && !seen_fail && t < 3000) begin
      @(negedge clk);
      t++;
      seen_done = done;
      seen_fail = fail;
    end
    $display("vector %0d", idx);
    chk("R5", "fail_o", int'(fail), int'(v.exp_fail));
    chk("R9", "status_o", int'(status), int'(v.exp_status));
    chk("R4", "final xover_o", int'(xover), int'(v.exp_xover));
    chk("R4", "xover per check", xover_err, 0);
    chk("R8", "read count", reads, int'(v.exp_reads));
    chk("R3", "phy address", addr_err, 0);
    chk("R2", "min wait before link check", int'(min_gap >= RETRY), 1);
    if (seen_done) begin
      st_hold = status;
      @(negedge clk);
      chk("R9", "done_o width", int'(done), 0);
      repeat (RETRY) @(negedge clk);
      chk("R9", "status hold", int'(status), int'(st_hold));
      chk("R9", "no request after done", reads, int'(v.exp_reads));
    end
    if (seen_fail) begin
      repeat (3 * RETRY) begin
        @(negedge clk);
        if (done) chk("R5", "done after fail", 1, 0);
      end
      chk("R5", "fail_o held", int'(fail), 1);
      chk("R5", "no request after fail", reads, int'(v.exp_reads));
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL R2 watchdog actual=expired expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int req_seen;
    cur = VECS[0];
    // R1 reset state and quiet first interval
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1", "xover_o in reset", int'(xover), 0);
    chk("R1", "fail_o in reset", int'(fail), 0);
    chk("R1", "done_o in reset", int'(done), 0);
    chk("R1", "status_o in reset", int'(status), 0);
    chk("R1", "mdio_req_o in reset", int'(req), 0);
    cur.link_at = 4'd15;
    n_att = 0; reads = 0; addr_err = 0; linked = 1'b0; min_gap = 1 << 30;
    rst_n = 1'b1;
    last_chk = cyc;
    req_seen = 0;
    repeat (RETRY) begin
      @(negedge clk);
      if (req) req_seen++;
    end
    chk("R1", "request during first wait", req_seen, 0);
    chk("R1", "xover_o after release", int'(xover), 0);

    // R6 R7 R8 vector walk
    foreach (VECS[i]) run_vec(VECS[i], i);

    // R7 unlisted code 7 with negotiation off: neither speed nor duplex
    cur = VECS[7];
    cur.code = 3'd7;
    cur.exp_status = 4'b0001;
    run_vec(cur, 8);
    // R7 10 Mb/s half with full pause chain: only pause and link
    cur = VECS[0];
    cur.code = 3'd1;
    cur.exp_status = 4'b1001;
    run_vec(cur, 9);
    // R6 link on last allowed check, bit 5 clear
    cur = VECS[4];
    cur.link_at = 4'd3;
    cur.exp_xover = 1'b1;
    cur.exp_reads = 4'd5;
    run_vec(cur, 10);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule